// File: doc/BRIEF.md
# ALU with Status Flag Register

This block is an integer arithmetic and logic unit with its own status flag register. Each request names an operation, an operand size (8, 16 or full width) and two operands. The unit returns the result and updates a nine-bit flag word. Six bits of that word describe the result: carry, parity, half-carry, zero, sign and overflow. The other three are control bits, trap, interrupt enable and direction, which are only changed by explicit set and clear operations.

Whether the flags change, and which of them change, depends on the operation. Add, subtract and compare rewrite all six result flags. Increment and decrement leave carry alone. The logic operations force carry, overflow and half-carry to zero. A move changes no flag. Compare and test update the flags but produce no result.

Requests arrive on a valid/ready stream and results leave on a second valid/ready stream. There is one output register between them. A request is taken whenever that register is empty or is being drained in the same cycle. When the consumer holds `out_ready` low, the output beat stays frozen and `in_ready` falls, so the back-pressure reaches the producer in the same cycle.

Top module: `afu_top`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. A request is accepted on a rising edge where both `in_valid` and `in_ready` are high. Its result beat is presented with `out_valid` high right after that edge. `out_valid` falls after an edge where `out_ready` is high and no new request is accepted.
- R2: While `out_valid` is high and `out_ready` is low, `out_data`, `out_wr` and `out_valid` keep their values.
- R3: `in_size` selects the operand width: 0 is 8 bits, 1 is 16 bits, 2 and 3 are the full `DATA_W`. Operands are truncated to that width, and `out_data` bits above the width are zero. Operation codes are: 0 add, 1 sub, 2 inc, 3 dec, 4 compare, 5 and, 6 or, 7 xor, 8 test, 9 move, 10 control-set, 11 control-clear. Codes 12 to 15 are reserved.
- R4: The `flags_o` bit positions are: 0 carry, 1 parity, 2 half-carry, 3 zero, 4 sign, 5 overflow, 6 direction, 7 interrupt enable, 8 trap. For add, sub and compare, carry is the carry out of (or the borrow into) the top bit of the selected width. Overflow is set when the signed result does not fit in that width.
- R5: For arithmetic operations, half-carry is the carry or borrow between bit 3 and bit 4.
- R6: For arithmetic and logic operations, parity is 1 when the low 8 bits of the result hold an even number of ones. Zero is 1 when the width-truncated result is zero. Sign is the top bit of the selected width.
- R7: Increment adds 1 and decrement subtracts 1. Both update parity, half-carry, zero, sign and overflow, and leave carry at its previous value.
- R8: And, or, xor and test clear carry, overflow and half-carry.
- R9: Compare and test update the flags, and their beat carries `out_wr` = 0 and `out_data` = 0. All operations that produce a result (add, sub, inc, dec, and, or, xor, move) carry `out_wr` = 1.
- R10: Move returns `in_b` truncated to the width and leaves all nine flags unchanged. Reserved codes return `out_wr` = 0 and `out_data` = 0, and leave the flags unchanged.
- R11: Control-set ORs `in_b[0]` into trap, `in_b[1]` into interrupt enable and `in_b[2]` into direction. Control-clear clears the bits selected the same way. Neither operation changes the six result flags, and both return `out_wr` = 0 and `out_data` = 0.
- R12: After reset, `flags_o` is 0, `out_valid` is 0 and `in_ready` is 1.
- R13: `flags_o` changes only on an edge where a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 4 | Operation code |
| in_size | input | 2 | Operand width select |
| in_a | input | DATA_W | First operand |
| in_b | input | DATA_W | Second operand or control mask |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_data | output | DATA_W | Result, zero when not written |
| out_wr | output | 1 | Result is meaningful for the destination |
| flags_o | output | 9 | Status flag register |

## Verification
The bench builds the unit with the default `DATA_W` of 32. With that width, all three size codes can be reached. The full-width overflow case at 7FFFFFFF + 1 can be driven, and so can the masking of a wide operand down to 8 and 16 bits. The narrow sizes reach the carry-out and borrow cases at FF and FFFF. Back-pressure phases that stall the output two cycles out of three put the hold rule and the same-cycle `in_ready` rule under load.

// File: rtl/afu_pkg.sv
package afu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_INC  = 4'd2,
    OP_DEC  = 4'd3,
    OP_CMP  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_TEST = 4'd8,
    OP_MOV  = 4'd9,
    OP_CSET = 4'd10,
    OP_CCLR = 4'd11
  } afu_op_e;

  // bit 0 is cf, bit 8 is trap
  typedef struct packed {
    logic trap;
    logic ien;
    logic dir;
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } afu_flags_t;

  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } afu_arith_t;

  localparam int AFU_FLAG_W = $bits(afu_flags_t);
  localparam int AFU_NSZ    = 3;

endpackage

// File: rtl/afu_datapath.sv
module afu_datapath
  import afu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  afu_op_e           op,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output afu_arith_t        raw
);
  localparam int IW = $clog2(DATA_W + 1);
  localparam int MW = $clog2(DATA_W);

  logic [DATA_W-1:0] mask_tab [AFU_NSZ];
  logic [IW-1:0]     cpos_tab [AFU_NSZ];
  logic [MW-1:0]     mpos_tab [AFU_NSZ];

  for (genvar g = 0; g < AFU_NSZ; g++) begin : g_size
    localparam int WG = (g == 0) ? 8 : (g == 1) ? 16 : DATA_W;
    assign mask_tab[g] = ~({DATA_W{1'b1}} << WG);
    assign cpos_tab[g] = IW'(WG);
    assign mpos_tab[g] = MW'(WG - 1);
  end

  logic [DATA_W-1:0] msk, aa, bb, rr, hmix;
  logic [DATA_W:0]   ext;
  logic [IW-1:0]     cpos;
  logic [MW-1:0]     mpos;
  logic              is_sub, a_m, b_m, r_m;

  always_comb begin
    case (size)
      2'd0:    begin msk = mask_tab[0]; cpos = cpos_tab[0]; mpos = mpos_tab[0]; end
      2'd1:    begin msk = mask_tab[1]; cpos = cpos_tab[1]; mpos = mpos_tab[1]; end
      default: begin msk = mask_tab[2]; cpos = cpos_tab[2]; mpos = mpos_tab[2]; end
    endcase
    aa = a & msk;
    bb = (op == OP_INC || op == OP_DEC) ? DATA_W'(1) : (b & msk);
    is_sub = (op == OP_SUB) || (op == OP_CMP) || (op == OP_DEC);
    ext = is_sub ? ({1'b0, aa} - {1'b0, bb}) : ({1'b0, aa} + {1'b0, bb});
    case (op)
      OP_AND, OP_TEST: rr = aa & bb;
      OP_OR:           rr = aa | bb;
      OP_XOR:          rr = aa ^ bb;
      OP_MOV:          rr = bb;
      default:         rr = ext[DATA_W-1:0] & msk;
    endcase
    hmix = aa ^ bb ^ rr;
    a_m  = aa[mpos];
    b_m  = bb[mpos];
    r_m  = rr[mpos];
    raw.cf = ext[cpos];
    raw.pf = ~^rr[7:0];
    raw.af = hmix[4];
    raw.zf = (rr == '0);
    raw.sf = r_m;
    raw.of = is_sub ? ((a_m != b_m) && (r_m != a_m))
                    : ((a_m == b_m) && (r_m != a_m));
    res = rr;
  end

endmodule

// File: rtl/afu_flag_next.sv
module afu_flag_next
  import afu_pkg::*;
(
  input  afu_op_e    op,
  input  afu_flags_t cur,
  input  afu_arith_t raw,
  input  logic [2:0] ctl_mask,
  output afu_flags_t nxt,
  output logic       wr
);
  always_comb begin
    nxt = cur;
    wr  = 1'b0;
    case (op)
      OP_ADD, OP_SUB, OP_CMP: begin
        {nxt.of, nxt.sf, nxt.zf, nxt.af, nxt.pf, nxt.cf} = raw;
        wr = (op != OP_CMP);
      end
      OP_INC, OP_DEC: begin
        {nxt.of, nxt.sf, nxt.zf, nxt.af, nxt.pf} = {raw.of, raw.sf, raw.zf, raw.af, raw.pf};
        wr = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR, OP_TEST: begin
        nxt.pf = raw.pf;
        nxt.zf = raw.zf;
        nxt.sf = raw.sf;
        nxt.cf = 1'b0;
        nxt.of = 1'b0;
        nxt.af = 1'b0;
        wr = (op != OP_TEST);
      end
      OP_MOV: wr = 1'b1;
      OP_CSET: begin
        nxt.trap = cur.trap | ctl_mask[0];
        nxt.ien  = cur.ien  | ctl_mask[1];
        nxt.dir  = cur.dir  | ctl_mask[2];
      end
      OP_CCLR: begin
        nxt.trap = cur.trap & ~ctl_mask[0];
        nxt.ien  = cur.ien  & ~ctl_mask[1];
        nxt.dir  = cur.dir  & ~ctl_mask[2];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/afu_top.sv
module afu_top
  import afu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [3:0]            in_op,
  input  logic [1:0]            in_size,
  input  logic [DATA_W-1:0]     in_a,
  input  logic [DATA_W-1:0]     in_b,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [DATA_W-1:0]     out_data,
  output logic                  out_wr,
  output logic [AFU_FLAG_W-1:0] flags_o
);
  afu_op_e           op;
  afu_arith_t        raw;
  afu_flags_t        flags_q, flags_n;
  logic [DATA_W-1:0] res;
  logic              wr_n, take;

  assign op       = afu_op_e'(in_op);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  afu_datapath #(.DATA_W(DATA_W)) u_dp (
    .op   (op),
    .size (in_size),
    .a    (in_a),
    .b    (in_b),
    .res  (res),
    .raw  (raw)
  );

  afu_flag_next u_fn (
    .op       (op),
    .cur      (flags_q),
    .raw      (raw),
    .ctl_mask (in_b[2:0]),
    .nxt      (flags_n),
    .wr       (wr_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_wr    <= 1'b0;
    end else if (take) begin
      flags_q   <= flags_n;
      out_valid <= 1'b1;
      out_data  <= wr_n ? res : '0;
      out_wr    <= wr_n;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign flags_o = flags_q;

endmodule

// File: rtl/afu_checker.sv
module afu_checker
  import afu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [3:0]            in_op,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [DATA_W-1:0]     out_data,
  input logic                  out_wr,
  input logic [AFU_FLAG_W-1:0] flags_o
);
  logic acc, is_logic, is_cmp, is_incdec, is_res;
  assign acc       = in_valid && in_ready;
  assign is_logic  = in_op inside {4'd5, 4'd6, 4'd7, 4'd8};
  assign is_cmp    = in_op inside {4'd4, 4'd8};
  assign is_incdec = in_op inside {4'd2, 4'd3};
  assign is_res    = in_op inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd5, 4'd6, 4'd7};

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_wr)); // R2
  AST_MOV_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 4'd9 |=> $stable(flags_o)); // R10
  AST_LOGIC_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_logic |=> !flags_o[0] && !flags_o[5] && !flags_o[2]); // R8
  AST_INCDEC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_incdec |=> flags_o[0] == $past(flags_o[0])); // R7
  AST_CMP_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_cmp |=> out_valid && !out_wr && out_data == '0); // R9
  AST_IDLE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(flags_o)); // R13
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_res |=> flags_o[3] == (out_data == '0)); // R6
  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R1
endmodule

bind afu_top afu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_op     (in_op),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_wr    (out_wr),
  .flags_o   (flags_o)
);

// File: tb/afu_top_test.sv
module afu_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [1:0]  in_size = '0;
  logic [31:0] in_a = '0, in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        out_wr;
  logic [8:0]  flags_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit bp = 1'b0;
  logic [8:0] mflags = '0;
  logic [41:0] expq[$];
  string tagq[$];

  always #10 clk = ~clk;

  afu_top #(.DATA_W(32)) uut (.*);

  task automatic check(input string tag, input string what, input logic [41:0] act, input logic [41:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [41:0] model(input logic [3:0] op, input logic [1:0] sz,
                                        input logic [31:0] a, input logic [31:0] b,
                                        input logic [8:0] f);
    int w;
    logic [31:0] m, x, y, r, h;
    logic [32:0] s;
    logic c, ov, wr;
    logic [8:0] n;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    x = a & m; y = b & m; n = f; wr = 1'b0; r = '0;
    if (op <= 4'd4) begin
      if (op == 4'd2 || op == 4'd3) y = 32'h1;
      if (op == 4'd0 || op == 4'd2) begin
        s = {1'b0, x} + {1'b0, y}; c = s[w];
        r = s[31:0] & m;
        ov = (x[w-1] == y[w-1]) && (r[w-1] != x[w-1]);
      end else begin
        s = {1'b0, x} - {1'b0, y}; c = (x < y);
        r = s[31:0] & m;
        ov = (x[w-1] != y[w-1]) && (r[w-1] != x[w-1]);
      end
      h = x ^ y ^ r;
      if (!(op == 4'd2 || op == 4'd3)) n[0] = c;
      n[1] = ~^r[7:0]; n[2] = h[4]; n[3] = (r == 0); n[4] = r[w-1]; n[5] = ov;
      wr = (op != 4'd4);
    end else if (op <= 4'd8) begin
      r = (op == 4'd6) ? (x | y) : (op == 4'd7) ? (x ^ y) : (x & y);
      n[0] = 1'b0; n[2] = 1'b0; n[5] = 1'b0;
      n[1] = ~^r[7:0]; n[3] = (r == 0); n[4] = r[w-1];
      wr = (op != 4'd8);
    end else if (op == 4'd9) begin
      r = y; wr = 1'b1;
    end else if (op == 4'd10) begin
      n[8] = f[8] | b[0]; n[7] = f[7] | b[1]; n[6] = f[6] | b[2];
    end else if (op == 4'd11) begin
      n[8] = f[8] & ~b[0]; n[7] = f[7] & ~b[1]; n[6] = f[6] & ~b[2];
    end
    if (!wr) r = '0;
    return {n, wr, r};
  endfunction

  // driver: computes the expected beat and pushes it to the scoreboard queue
  task automatic send(input string tag, input logic [3:0] op, input logic [1:0] sz,
                      input logic [31:0] a, input logic [31:0] b);
    logic [41:0] e;
    @(negedge clk);
    e = model(op, sz, a, b, mflags);
    mflags = e[41:33];
    expq.push_back(e);
    tagq.push_back(tag);
    in_op = op; in_size = sz; in_a = a; in_b = b; in_valid = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor
  initial forever begin
    @(negedge clk);
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0) check("R1", "unexpected beat", 42'(out_data), 42'h0);
      else begin
        logic [41:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check(t, "beat {flags,wr,data}", {flags_o, out_wr, out_data}, e);
      end
    end
  end

  initial forever begin
    @(posedge clk); #2;
    cyc++;
    out_ready = bp ? (cyc % 3 == 0) : 1'b1;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired pending=%0d expected=0", expq.size());
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [8:0] snap;
    repeat (3) @(negedge clk);
    check("R12", "reset flags/valid/ready", {flags_o, out_valid, in_ready}, {9'h0, 1'b0, 1'b1});
    rst_n = 1'b1;
    // R4 R5 R6: carry, half-carry, zero and parity at 8 bits
    send("R4", 4'd0, 2'd0, 32'h0000_00FF, 32'h0000_0001);
    send("R4", 4'd0, 2'd2, 32'h7FFF_FFFF, 32'h0000_0001);
    send("R4", 4'd1, 2'd1, 32'h0000_0000, 32'h0000_0001);
    send("R4", 4'd4, 2'd0, 32'h0000_0080, 32'h0000_0001);
    send("R5", 4'd0, 2'd0, 32'h0000_000F, 32'h0000_0001);
    send("R5", 4'd1, 2'd1, 32'h0000_0010, 32'h0000_0001);
    send("R3", 4'd0, 2'd0, 32'h1234_5678, 32'h1111_1111);
    send("R3", 4'd1, 2'd1, 32'hABCD_1234, 32'h0000_2345);
    send("R3", 4'd0, 2'd3, 32'h8000_0000, 32'h8000_0000);
    send("R6", 4'd5, 2'd2, 32'h0000_0103, 32'hFFFF_FFFF);
    send("R6", 4'd6, 2'd2, 32'h8000_0000, 32'h0000_0007);
    // R7: carry survives inc/dec
    send("R7", 4'd0, 2'd0, 32'h0000_00FF, 32'h0000_0001);
    send("R7", 4'd2, 2'd0, 32'h0000_00FF, 32'h0);
    send("R7", 4'd3, 2'd1, 32'h0000_0000, 32'h0);
    send("R7", 4'd2, 2'd0, 32'h0000_007F, 32'h0);
    // R8: logic ops clear carry/overflow/half-carry
    send("R8", 4'd0, 2'd2, 32'h7FFF_FFFF, 32'h0000_0001);
    send("R8", 4'd7, 2'd2, 32'hFFFF_0000, 32'h0F0F_0F0F);
    // R9: no result for compare/test
    send("R9", 4'd4, 2'd1, 32'h0000_1234, 32'h0000_1234);
    send("R9", 4'd8, 2'd0, 32'h0000_00F0, 32'h0000_000F);
    // R10: move passes b, flags unchanged; reserved codes do nothing
    send("R10", 4'd9, 2'd1, 32'h0, 32'hDEAD_BEEF);
    send("R10", 4'd15, 2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // R11: control bits
    send("R11", 4'd10, 2'd0, 32'h0, 32'h0000_0007);
    send("R11", 4'd11, 2'd0, 32'h0, 32'h0000_0002);
    send("R11", 4'd10, 2'd0, 32'h0, 32'h0000_0000);
    // R1 R2: back-pressure
    bp = 1'b1;
    send("R2", 4'd0, 2'd1, 32'h0000_FFFE, 32'h0000_0003);
    send("R2", 4'd3, 2'd2, 32'h8000_0000, 32'h0);
    send("R1", 4'd6, 2'd0, 32'h0000_0000, 32'h0000_0000);
    send("R1", 4'd1, 2'd0, 32'h0000_0005, 32'h0000_0009);
    send("R2", 4'd9, 2'd0, 32'h0, 32'h0000_0155);
    drain();
    bp = 1'b0;
    repeat (4) @(negedge clk);
    check("R1", "valid after drain", {41'h0, out_valid}, 42'h0);
    // R13: flags hold while idle
    snap = flags_o;
    repeat (5) @(negedge clk);
    check("R13", "flags idle", 42'(flags_o), 42'(snap));
    drain();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule